// File: doc/BRIEF.md
# Remote Control Page Write-Verify Sequencer

This block updates one page of a remote control register. The register is reached through a serial exchange master, and each exchange sends a 32-bit command and returns a 32-bit status word. On a start pulse the sequencer runs three steps. It sends the caller's control word unchanged as a read and keeps the status that comes back. It then sends a write command built from that status: the event bits are cleared, the write-enable bit is set and the action bits are ORed in.

If the write targets page 0, the sequencer reads page 0 back and retries until a masked comparison passes or the retry budget is spent. If the write targets any other page, it waits a fixed number of clock cycles and then reports success. A serial error at any step stops the sequence at once.

The outcome is shown as a 2-bit result code, together with a one-cycle completion pulse. The code stays unchanged until the next start. The bit positions of the fields, the compare mask, the retry budget and the settle time are all parameters.

Top module: `wv_seq`

## Requirements
- R1: After reset, busy, done and xfer_req are 0 and result is 0 (no outcome yet). The result encoding is 0 none, 1 success, 2 invalid argument (serial error), 3 write failure.
- R2: The first exchange of a sequence carries ctrl_word exactly as it was sampled on the start cycle.
- R3: The second exchange carries (first status AND NOT event_mask) OR action_bits OR the write-enable bit, which is bit 27 by default.
- R4: When the write command's page field (bits 31:30) is 0, the sequencer issues verify reads with an all-zero command word. A read-back passes when three things hold: its bits 23:0 equal those of the write command, its page field is 0, and its status-off bit (bit 25) is 1. On a pass it reports success.
- R5: At most 6 verify reads are made. If the 6th read fails, the result is 3 and no further exchange is issued.
- R6: A read-back whose page field differs from the command's page fails the check, even when all the compared bits match.
- R7: A read-back with the status-off bit at 0 fails the check, even when all other bits match.
- R8: When the write command's page field is non-zero, no verify read is made. Done rises exactly SETTLE_CYC+1 cycles after the cycle in which the write exchange completed, and the result is 1.
- R9: A serial error reported with any exchange completion ends the sequence right away with result 2, and no further exchange is issued.
- R10: Done is a single-cycle pulse. Busy is high from the cycle after start until done. The result holds its value while idle until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, accepted while idle |
| ctrl_word | input | 32 | Read command for the target page |
| event_mask | input | 32 | Bits to clear in the returned status |
| action_bits | input | 32 | Bits to set in the write command |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | Outcome code, held until the next start |
| xfer_req | output | 1 | Exchange request to the serial master |
| xfer_cmd | output | 32 | Command word for the current exchange |
| xfer_done | input | 1 | Exchange complete pulse |
| xfer_rdata | input | 32 | Status word returned by the exchange |
| xfer_err | input | 1 | Exchange failed, valid with xfer_done |

## Verification
The bench targets the retry boundary. A design off by one would give up after the 5th read, or issue a 7th, and the exchange count shows either error. It also feeds read-backs that fail for only one reason each: a wrong page field, a cleared status-off bit, or a single mismatched data bit. A check that ignored any of these would report success too early. Serial errors are injected on the first read and in the middle of the retries, where a design that carried on would issue extra exchanges. The settle path is timed to the exact cycle, and the held result is watched across idle cycles.

// File: rtl/wv_pkg.sv
package wv_pkg;
  typedef enum logic [1:0] {
    RC_NONE  = 2'd0,
    RC_OK    = 2'd1,
    RC_INVAL = 2'd2,
    RC_WFAIL = 2'd3
  } wv_rc_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RD   = 3'd1,
    ST_WR   = 3'd2,
    ST_VF   = 3'd3,
    ST_SET  = 3'd4
  } wv_st_e;
endpackage

// File: rtl/wv_check.sv
module wv_check #(
  parameter int DW        = 32,
  parameter int PG_HI     = 31,
  parameter int PG_LO     = 30,
  parameter int STOFF_POS = 25,
  parameter logic [DW-1:0] CMP_MASK = 32'h00FF_FFFF
) (
  input  logic [DW-1:0] cmd,
  input  logic [DW-1:0] rb,
  output logic          pass
);
  logic page_eq, data_eq, stoff;

  assign page_eq = (rb[PG_HI:PG_LO] == cmd[PG_HI:PG_LO]);
  assign data_eq = ((rb & CMP_MASK) == (cmd & CMP_MASK));
  assign stoff   = rb[STOFF_POS];
  assign pass    = page_eq && data_eq && stoff;
endmodule

// File: rtl/wv_settle.sv
module wv_settle #(
  parameter int SETTLE_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == CW'(SETTLE_CYC - 1));
endmodule

// File: rtl/wv_seq.sv
module wv_seq
  import wv_pkg::*;
#(
  parameter int DW         = 32,
  parameter int PG_HI      = 31,
  parameter int PG_LO      = 30,
  parameter int WE_POS     = 27,
  parameter int STOFF_POS  = 25,
  parameter logic [DW-1:0] CMP_MASK = 32'h00FF_FFFF,
  parameter int MAX_VERIFY = 6,
  parameter int SETTLE_CYC = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] ctrl_word,
  input  logic [DW-1:0] event_mask,
  input  logic [DW-1:0] action_bits,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result,
  output logic          xfer_req,
  output logic [DW-1:0] xfer_cmd,
  input  logic          xfer_done,
  input  logic [DW-1:0] xfer_rdata,
  input  logic          xfer_err
);
  localparam int TW = $clog2(MAX_VERIFY + 1);
  localparam logic [DW-1:0] WE_BIT = DW'(1) << WE_POS;
  localparam logic [DW-1:0] VF_CMD = '0;

  function automatic logic [DW-1:0] mk_write(input logic [DW-1:0] st,
                                             input logic [DW-1:0] ev,
                                             input logic [DW-1:0] act);
    return (st & ~ev) | WE_BIT | act;
  endfunction

  wv_st_e        state;
  wv_rc_e        rc_q;
  logic [DW-1:0] ctrl_q, ev_q, act_q, wr_q;
  logic [TW-1:0] tries;
  logic          done_q;
  logic          vf_pass, settle_exp;

  // named internal events
  logic ev_xfer_ok, ev_abort, ev_wr_issue, ev_vf_miss_last;
  assign ev_xfer_ok      = xfer_req && xfer_done && !xfer_err;
  assign ev_abort        = xfer_req && xfer_done && xfer_err;
  assign ev_wr_issue     = (state == ST_WR) && xfer_req;
  assign ev_vf_miss_last = (state == ST_VF) && ev_xfer_ok && !vf_pass &&
                           (tries == TW'(MAX_VERIFY - 1));

  wv_check #(.DW(DW), .PG_HI(PG_HI), .PG_LO(PG_LO),
             .STOFF_POS(STOFF_POS), .CMP_MASK(CMP_MASK)) u_check (
    .cmd (wr_q),
    .rb  (xfer_rdata),
    .pass(vf_pass)
  );

  wv_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state == ST_SET),
    .expired(settle_exp)
  );

  always_comb begin
    xfer_req = 1'b0;
    xfer_cmd = '0;
    unique case (state)
      ST_RD:   begin xfer_req = 1'b1; xfer_cmd = ctrl_q; end
      ST_WR:   begin xfer_req = 1'b1; xfer_cmd = wr_q;   end
      ST_VF:   begin xfer_req = 1'b1; xfer_cmd = VF_CMD; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rc_q   <= RC_NONE;
      ctrl_q <= '0;
      ev_q   <= '0;
      act_q  <= '0;
      wr_q   <= '0;
      tries  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (ev_abort) begin
        state  <= ST_IDLE;
        rc_q   <= RC_INVAL;
        done_q <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: if (start) begin
            ctrl_q <= ctrl_word;
            ev_q   <= event_mask;
            act_q  <= action_bits;
            tries  <= '0;
            rc_q   <= RC_NONE;
            state  <= ST_RD;
          end
          ST_RD: if (ev_xfer_ok) begin
            wr_q  <= mk_write(xfer_rdata, ev_q, act_q);
            state <= ST_WR;
          end
          ST_WR: if (ev_xfer_ok) begin
            state <= (wr_q[PG_HI:PG_LO] == '0) ? ST_VF : ST_SET;
          end
          ST_VF: if (ev_xfer_ok) begin
            if (vf_pass) begin
              state  <= ST_IDLE;
              rc_q   <= RC_OK;
              done_q <= 1'b1;
            end else if (ev_vf_miss_last) begin
              state  <= ST_IDLE;
              rc_q   <= RC_WFAIL;
              done_q <= 1'b1;
            end else begin
              tries <= tries + 1'b1;
            end
          end
          ST_SET: if (settle_exp) begin
            state  <= ST_IDLE;
            rc_q   <= RC_OK;
            done_q <= 1'b1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy   = (state != ST_IDLE);
  assign done   = done_q;
  assign result = rc_q;

  // assertions
  a_r3_we_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_issue |-> xfer_cmd[WE_POS]);
  a_r5_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TW'(MAX_VERIFY));
  a_r5_last_miss_fails: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vf_miss_last |=> (done && result == RC_WFAIL && !xfer_req));
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> (done && result == RC_INVAL && !busy));
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(result));
endmodule

// File: tb/wv_seq_tb.sv
module wv_seq_tb;
  localparam int SETTLE = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] ctrl_word = '0, event_mask = '0, action_bits = '0;
  logic        busy, done, xfer_req;
  logic [1:0]  result;
  logic [31:0] xfer_cmd;
  logic        xfer_done = 1'b0, xfer_err = 1'b0;
  logic [31:0] xfer_rdata = '0;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;

  logic [31:0] resp [16];
  logic [31:0] cmds [16];
  int          xdone_cyc [16];
  int          n_x = 0;
  int          err_at = -1;
  int          done_cyc = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wv_seq #(.SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_word(ctrl_word),
    .event_mask(event_mask), .action_bits(action_bits), .busy(busy),
    .done(done), .result(result), .xfer_req(xfer_req), .xfer_cmd(xfer_cmd),
    .xfer_done(xfer_done), .xfer_rdata(xfer_rdata), .xfer_err(xfer_err)
  );

  // serial master model: scripted responses
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && xfer_req) begin
        if (n_x < 16) cmds[n_x] = xfer_cmd;
        repeat (2) @(negedge clk);
        xfer_rdata = resp[n_x % 16];
        xfer_err   = (n_x == err_at);
        xfer_done  = 1'b1;
        xdone_cyc[n_x % 16] = cyc;
        n_x++;
        @(negedge clk);
        xfer_done = 1'b0;
        xfer_err  = 1'b0;
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wr(logic [31:0] st, logic [31:0] ev, logic [31:0] ac);
    logic [31:0] w;
    w = st;
    for (int b = 0; b < 32; b++) begin
      if (ev[b]) w[b] = 1'b0;
      if (ac[b]) w[b] = 1'b1;
    end
    w[27] = 1'b1;
    return w;
  endfunction

  task automatic run_seq(logic [31:0] c, logic [31:0] e, logic [31:0] a, int err_idx);
    int t;
    n_x = 0;
    err_at = err_idx;
    @(negedge clk);
    ctrl_word = c; event_mask = e; action_bits = a; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10 busy after start", {31'b0, busy}, 32'd1);
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    done_cyc = cyc;
    check("R10 done seen", {31'b0, done}, 32'd1);
    @(negedge clk);
    check("R10 done single pulse", {31'b0, done}, 32'd0);
    check("R10 idle after done", {31'b0, busy}, 32'd0);
  endtask

  // page 0, first verify read passes
  task automatic t_page0_pass();
    logic [31:0] rd, w;
    rd = 32'h0012_3456;
    w  = exp_wr(rd, 32'h0000_0F00, 32'h0000_0A00);
    resp[0] = rd; resp[1] = 32'h0; resp[2] = (w & 32'h00FF_FFFF) | 32'h0200_0000;
    run_seq(32'h0000_0000, 32'h0000_0F00, 32'h0000_0A00, -1);
    check("R2 read carries ctrl_word", cmds[0], 32'h0000_0000);
    check("R3 write command", cmds[1], 32'h0812_3A56);
    check("R4 verify command zero", cmds[2], 32'h0);
    check("R4 exchange count", n_x, 3);
    check("R4 result success", {30'b0, result}, 32'd1);
  endtask

  // page 0, six failing read-backs
  task automatic t_page0_exhaust();
    resp[0] = 32'h0012_3456; resp[1] = 32'h0;
    for (int k = 2; k < 8; k++) resp[k] = 32'h0012_3A56;
    run_seq(32'h0000_00C3, 32'h0000_0F00, 32'h0000_0A00, -1);
    check("R2 read carries ctrl_word", cmds[0], 32'h0000_00C3);
    check("R5 six verify reads then stop", n_x, 8);
    check("R5 result write failure", {30'b0, result}, 32'd3);
  endtask

  // page 0, single-cause misses then pass on 4th verify
  task automatic t_page0_late_pass();
    resp[0] = 32'h0012_3456; resp[1] = 32'h0;
    resp[2] = 32'h4212_3A56;   // page field wrong
    resp[3] = 32'h0012_3A56;   // status-off clear
    resp[4] = 32'h0212_3A57;   // data bit differs
    resp[5] = 32'h0212_3A56;   // good
    run_seq(32'h0000_0000, 32'h0000_0F00, 32'h0000_0A00, -1);
    check("R6 R7 misses retried, pass on 4th", n_x, 6);
    check("R6 R7 result success", {30'b0, result}, 32'd1);
  endtask

  // non-zero page: settle only
  task automatic t_page1_settle();
    resp[0] = 32'h4000_0001; resp[1] = 32'h0;
    run_seq(32'h4000_0000, 32'h0, 32'h0, -1);
    check("R3 page1 write command", cmds[1], 32'h4800_0001);
    check("R8 no verify reads", n_x, 2);
    check("R8 settle timing", done_cyc - xdone_cyc[1], SETTLE + 1);
    check("R8 result success", {30'b0, result}, 32'd1);
  endtask

  task automatic t_err_first();
    resp[0] = 32'h0012_3456;
    run_seq(32'h0000_0000, 32'h0, 32'h0, 0);
    check("R9 abort after first read", n_x, 1);
    check("R9 result invalid", {30'b0, result}, 32'd2);
  endtask

  task automatic t_err_verify();
    resp[0] = 32'h0012_3456; resp[1] = 32'h0;
    resp[2] = 32'h0; resp[3] = 32'h0212_3A56;
    run_seq(32'h0000_0000, 32'h0000_0F00, 32'h0000_0A00, 3);
    check("R9 abort during verify", n_x, 4);
    check("R9 result invalid", {30'b0, result}, 32'd2);
  endtask

  task automatic t_hold();
    repeat (30) @(negedge clk);
    check("R10 result held while idle", {30'b0, result}, 32'd2);
    check("R10 no exchange while idle", {31'b0, xfer_req}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 result", {30'b0, result}, 32'd0);
    check("R1 xfer_req", {31'b0, xfer_req}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle after release", {31'b0, busy}, 32'd0);
    t_page0_pass();
    t_page0_exhaust();
    t_page0_late_pass();
    t_page1_settle();
    t_err_first();
    t_err_verify();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule